// File: doc/BRIEF.md
# Execute Unit with Flag Register and Condition Test

This block is the arithmetic and condition stage of a single-cycle processor datapath. Each cycle it takes two 64-bit operands, the instruction's major code and function code, and produces the arithmetic result. For arithmetic/logic instructions the function code picks one of four operations: add, subtract, bitwise AND or bitwise XOR. Every other instruction class uses an add, which covers address and stack-pointer arithmetic.

Two flag bits, zero and sign, are held in registers. They take new values at the rising clock edge, and only when an arithmetic/logic instruction runs with its flag-write enable set. Jumps and conditional moves test these flags in the cycle they execute, so the test sees the flags left by an earlier instruction, not by the current result. A conditional move whose test fails cancels its register write by replacing the requested destination with register number 0xF.

Top module: `exec_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the zero flag to 1 and clears the sign flag.
- R2: With `icode` = 6 (arithmetic/logic), `res` is, by `ifun`: 0 → `opb + opa`, 1 → `opb - opa`, 2 → `opb & opa`, 3 → `opb ^ opa`, all modulo 2^64.
- R3: With `icode` = 6 and `ifun` from 4 to 15, `res` is `opb + opa`.
- R4: With any `icode` other than 6, `res` is `opb + opa` whatever `ifun` is.
- R5: At a rising edge with `icode` = 6 and `cc_en` = 1 (reset low), the zero flag becomes 1 exactly when `res` is 0, and the sign flag becomes bit 63 of `res`.
- R6: At every other rising edge with reset low, both flags keep their values, including non-arithmetic instructions with `cc_en` = 1 and arithmetic ones with `cc_en` = 0.
- R7: For `icode` = 7 (jump) or 2 (conditional move), `cnd` is decided by `ifun` from the registered flags: 0 → 1; 1 → SF or ZF; 2 → SF; 3 → ZF; 4 → not ZF; 5 → not SF; 6 → not SF and not ZF.
- R8: For `icode` 7 or 2 with `ifun` from 7 to 15, `cnd` is 0; for any other `icode`, `cnd` is 0.
- R9: `dst_out` is 0xF when `icode` = 2 and `cnd` = 0; in every other case it equals `dst_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| icode | input | 4 | Instruction major code |
| ifun | input | 4 | Instruction function code |
| opa | input | 64 | First ALU operand |
| opb | input | 64 | Second ALU operand |
| cc_en | input | 1 | Flag-write enable |
| dst_in | input | 4 | Requested result-register number |
| res | output | 64 | ALU result |
| cnd | output | 1 | Condition outcome |
| dst_out | output | 4 | Result-register number after the conditional-move override |
| zf | output | 1 | Registered zero flag |
| sf | output | 1 | Registered sign flag |

## Verification
The assertions assume that `rst` is high at the first clock edge, so the flags hold known values before any property is enabled, and that every input is a known value one edge before each sampled one. The bench holds reset over the first edges and changes inputs only on the falling edge, so each edge samples settled, defined inputs. Random stimulus weights the major code toward the arithmetic, jump and conditional-move classes and often makes the operands equal or sets their top bits, so zero and negative results occur often enough to drive every condition code both ways.

// File: rtl/exec_unit.sv
module exec_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   icode,
  input  logic [3:0]   ifun,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cc_en,
  input  logic [3:0]   dst_in,
  output logic [W-1:0] res,
  output logic         cnd,
  output logic [3:0]   dst_out,
  output logic         zf,
  output logic         sf
);
  localparam logic [3:0] IC_MOVE = 4'h2;
  localparam logic [3:0] IC_ARITH = 4'h6;
  localparam logic [3:0] IC_JUMP = 4'h7;
  localparam logic [3:0] NO_REG = 4'hF;

  logic is_arith, is_cond;
  assign is_arith = (icode == IC_ARITH);
  assign is_cond = (icode == IC_JUMP) || (icode == IC_MOVE);

  always_comb begin
    res = opb + opa;
    if (is_arith) begin
      case (ifun)
        4'h1: res = opb - opa;
        4'h2: res = opb & opa;
        4'h3: res = opb ^ opa;
        default: res = opb + opa;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zf <= 1'b1;
      sf <= 1'b0;
    end else if (is_arith && cc_en) begin
      zf <= (res == '0);
      sf <= res[W-1];
    end
  end

  logic test;
  always_comb begin
    case (ifun)
      4'h0: test = 1'b1;
      4'h1: test = sf | zf;
      4'h2: test = sf;
      4'h3: test = zf;
      4'h4: test = ~zf;
      4'h5: test = ~sf;
      4'h6: test = ~sf & ~zf;
      default: test = 1'b0;
    endcase
  end

  assign cnd = is_cond & test;
  assign dst_out = (icode == IC_MOVE && !cnd) ? NO_REG : dst_in;
endmodule

module exec_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   icode,
  input logic [3:0]   ifun,
  input logic         cc_en,
  input logic [3:0]   dst_in,
  input logic [W-1:0] res,
  input logic         cnd,
  input logic [3:0]   dst_out,
  input logic         zf,
  input logic         sf
);
  a_r1_reset_flags: assert property (@(posedge clk) rst |=> (zf && !sf));

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (icode == 4'h6 && cc_en) |=> (zf == ($past(res) == '0)));

  a_r5_sign_flag: assert property (@(posedge clk) disable iff (rst)
    (icode == 4'h6 && cc_en) |=> (sf == $past(res[W-1])));

  a_r6_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !(icode == 4'h6 && cc_en) |=> ($stable(zf) && $stable(sf)));

  a_r7_always_taken: assert property (@(posedge clk) disable iff (rst)
    ((icode == 4'h7 || icode == 4'h2) && ifun == 4'h0) |-> cnd);

  a_r8_no_cond: assert property (@(posedge clk) disable iff (rst)
    !(icode == 4'h7 || icode == 4'h2) |-> !cnd);

  a_r9_cancel: assert property (@(posedge clk) disable iff (rst)
    (icode == 4'h2 && !cnd) |-> (dst_out == 4'hF));

  a_r9_pass: assert property (@(posedge clk) disable iff (rst)
    !(icode == 4'h2 && !cnd) |-> (dst_out == dst_in));
endmodule

bind exec_unit exec_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .icode(icode), .ifun(ifun), .cc_en(cc_en),
  .dst_in(dst_in), .res(res), .cnd(cnd), .dst_out(dst_out), .zf(zf), .sf(sf)
);

// File: tb/exec_unit_tb_top.sv
`timescale 1ns/1ps
module exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  icode = '0, ifun = '0, dst_in = '0;
  logic [63:0] opa = '0, opb = '0;
  logic        cc_en = 1'b0;
  logic [63:0] res;
  logic        cnd, zf, sf;
  logic [3:0]  dst_out;

  int total = 0;
  int bad = 0;
  bit mzf, msf;

  always #2.5 clk = ~clk;

  exec_unit dut_i (
    .clk(clk), .rst(rst), .icode(icode), .ifun(ifun), .opa(opa), .opb(opb),
    .cc_en(cc_en), .dst_in(dst_in), .res(res), .cnd(cnd), .dst_out(dst_out),
    .zf(zf), .sf(sf)
  );

  function automatic logic [63:0] exp_res(logic [3:0] ic, logic [3:0] fn,
                                          logic [63:0] a, logic [63:0] b);
    if (ic != 4'h6) return b + a;
    if (fn == 4'h1) return b - a;
    if (fn == 4'h2) return b & a;
    if (fn == 4'h3) return b ^ a;
    return b + a;
  endfunction

  function automatic bit exp_cnd(logic [3:0] ic, logic [3:0] fn, bit z, bit s);
    if (ic != 4'h7 && ic != 4'h2) return 1'b0;
    case (fn)
      4'h0: return 1'b1;
      4'h1: return s || z;
      4'h2: return s;
      4'h3: return z;
      4'h4: return !z;
      4'h5: return !s;
      4'h6: return !s && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, check before the rising edge, then advance the model
  task automatic step(logic [3:0] ic, logic [3:0] fn, logic [63:0] a,
                      logic [63:0] b, bit en, logic [3:0] d);
    logic [63:0] er;
    bit ec;
    @(negedge clk);
    icode = ic; ifun = fn; opa = a; opb = b; cc_en = en; dst_in = d;
    #1;
    er = exp_res(ic, fn, a, b);
    ec = exp_cnd(ic, fn, mzf, msf);
    chk(res == er, (ic == 4'h6) ? ((fn < 4) ? "R2" : "R3") : "R4", res, er);
    chk(cnd == ec, (ic == 4'h7 || ic == 4'h2) && fn < 7 ? "R7" : "R8",
        {63'd0, cnd}, {63'd0, ec});
    chk(dst_out == ((ic == 4'h2 && !ec) ? 4'hF : d), "R9",
        {60'd0, dst_out}, {60'd0, (ic == 4'h2 && !ec) ? 4'hF : d});
    chk(zf == mzf && sf == msf, (ic == 4'h6 && en) ? "R5" : "R6",
        {62'd0, zf, sf}, {62'd0, mzf, msf});
    if (ic == 4'h6 && en) begin
      mzf = (er == 64'd0);
      msf = er[63];
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(zf == 1'b1 && sf == 1'b0, "R1", {62'd0, zf, sf}, 64'd2);
    mzf = 1'b1; msf = 1'b0;

    // directed: equal subtract gives zero, then every condition code
    step(4'h6, 4'h1, 64'd77, 64'd77, 1'b1, 4'h3);
    for (int c = 0; c < 16; c++) step(4'h7, c[3:0], 64'd1, 64'd2, 1'b0, 4'h1);
    // negative result sets sign
    step(4'h6, 4'h1, 64'd5, 64'd2, 1'b1, 4'h3);
    for (int c = 0; c < 16; c++) step(4'h2, c[3:0], 64'd0, 64'd9, 1'b0, 4'h4);
    // positive nonzero
    step(4'h6, 4'h0, 64'd5, 64'd2, 1'b1, 4'h3);
    for (int c = 0; c < 8; c++) step(4'h2, c[3:0], 64'd0, 64'd9, 1'b0, 4'h5);
    // non-arithmetic with enable and arithmetic without enable leave flags
    step(4'h5, 4'h1, 64'd3, 64'd3, 1'b1, 4'h6);
    step(4'h6, 4'h1, 64'd3, 64'd3, 1'b0, 4'h6);
    step(4'h2, 4'h3, 64'd0, 64'd0, 1'b0, 4'h7);
    // wrap-around add and ALU ifun beyond 3
    step(4'h6, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1, 4'h0);
    step(4'h6, 4'hA, 64'h8000_0000_0000_0000, 64'd1, 1'b1, 4'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ic, fn;
      logic [63:0] a, b;
      int sel;
      sel = $urandom_range(0, 9);
      ic = (sel < 4) ? 4'h6 : (sel < 6) ? 4'h7 : (sel < 8) ? 4'h2 : 4'($urandom);
      fn = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'($urandom_range(0, 6));
      a = {$urandom, $urandom};
      b = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b[63] = 1'b1;
      step(ic, fn, a, b, 1'($urandom), 4'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule